// File: doc/BRIEF.md
# Whole-Method Instruction Cache

This block is an instruction cache that stores complete methods instead of fixed lines. Its storage is cut into equal blocks. A method is kept in one or more neighbouring blocks, wrapping from the last block to block 0. The cache looks anything up only when the core calls or returns into a method. At that point the core presents the method's main-memory address and its length in words. Ordinary instruction fetches inside the current method need no tag check. They give a word offset relative to the start of the method, and the cache adds that offset to the first block of the method.

When a lookup misses, the cache reads every word of the method from main memory, one read per cycle. It stores the method starting at the block named by a rotating placement pointer. Then the pointer moves past the blocks just used. Each block has one tag slot. The slot of a method's first block holds the method address and how many blocks the method spans. When a new method is placed, every resident method that shares a block with it is dropped. While a lookup or fill is in progress, `busy` is high. The core waits for `busy` to fall before it fetches from the new method.

The controller has four states. `ST_IDLE` waits for a request. `ST_LOOKUP` compares the captured address against the tags and checks the length. `ST_FILL` issues one main-memory read per cycle. `ST_LAST` writes the final returned word. The transitions are:
- IDLE→LOOKUP when a request arrives.
- LOOKUP→IDLE on a hit or on a rejected length.
- LOOKUP→FILL on a miss.
- FILL→FILL while reads remain.
- FILL→LAST after the final read is issued.
- LAST→IDLE unconditionally.

Top module: `method_cache`

## Requirements
- R1: After reset, `busy`, `err` and `mem_rd_en` are low, every tag slot is empty and the placement pointer is block 0, so the first request of any method misses.
- R2: A request is taken only in a cycle where `busy` is low. `req_valid` raised while `busy` is high is ignored: the running operation keeps its length and no further busy period follows it.
- R3: A request whose address matches a resident method holds `busy` high for exactly 1 cycle and issues no memory read. Afterwards, fetches address that method.
- R4: A miss for a method of L words holds `busy` high for exactly L+2 cycles. Reads are issued in busy cycles 2 to L+1, at the consecutive addresses A, A+1, …, A+L-1. Memory data arrives one cycle after each read. `busy` falls only after the last word has been written.
- R5: A missed method is placed at the block held by the placement pointer. The pointer then advances by ceil(L / BLK_WORDS), modulo BLK_NUM.
- R6: Placing a method drops every resident method that occupies any block it overwrites, including blocks it does not fully cover. A later request for a dropped method misses.
- R7: `fetch_data` is valid one cycle after `fetch_addr` is applied. It returns word `fetch_addr` of the current method, which lives at cache word (base_block·BLK_WORDS + fetch_addr) mod (BLK_NUM·BLK_WORDS), so offsets past the last block wrap to block 0.
- R8: A length of 0, or a length larger than BLK_NUM·BLK_WORDS, is rejected. `busy` is high for 1 cycle, no read is issued, tags, pointer and current method stay unchanged, and `err` is set. `err` stays high until the next request is taken.
- R9: When a fetch reads the cache word that the fill writes in the same cycle, `fetch_data` returns the word's previous content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Call/return lookup request |
| req_addr | input | ADDR_W | Main-memory word address of the method |
| req_len | input | LEN_W | Method length in words |
| busy | output | 1 | Lookup or fill in progress |
| err | output | 1 | Last request had an illegal length |
| mem_rd_en | output | 1 | Main-memory read strobe |
| mem_rd_addr | output | ADDR_W | Main-memory read address |
| mem_rd_data | input | DATA_W | Read data, one cycle after the strobe |
| fetch_addr | input | CA_W | Word offset inside the current method |
| fetch_data | output | DATA_W | Instruction word, registered |

## Verification
Two things can happen in the same cycle: the fetch read port reads a cache word, and the fill writes that same word. The bench provokes this by steering `fetch_addr` so that it follows the word being written during a fill that overwrites older content. Its reference model computes the registered read before applying the write, and any fetch compare made in such a cycle is judged as R9. Separately, stray requests are raised in the middle of a long fill, and the bench checks that the busy period and the memory read stream are unaffected.

// File: rtl/mc_pkg.sv
package mc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL,
        ST_LAST
    } mc_state_e;
endpackage

// File: rtl/mc_tags.sv
module mc_tags #(
    parameter int BLK_NUM = 8,
    parameter int ADDR_W  = 16,
    localparam int IDX_W  = $clog2(BLK_NUM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    input  logic              alloc,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [IDX_W:0]    alloc_span
);
    logic [BLK_NUM-1:0] vld_q;
    logic [ADDR_W-1:0]  tag_q  [BLK_NUM];
    logic [IDX_W:0]     span_q [BLK_NUM];
    logic [BLK_NUM-1:0] hit_vec;
    logic [BLK_NUM-1:0] clash_vec;

    for (genvar g = 0; g < BLK_NUM; g++) begin : g_slot
        logic [IDX_W-1:0] d_fwd;
        logic [IDX_W-1:0] d_bwd;
        assign d_fwd        = alloc_idx - IDX_W'(g);
        assign d_bwd        = IDX_W'(g) - alloc_idx;
        assign hit_vec[g]   = vld_q[g] && (tag_q[g] == look_addr);
        assign clash_vec[g] = vld_q[g] && (({1'b0, d_fwd} < span_q[g]) ||
                                           ({1'b0, d_bwd} < alloc_span));
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = BLK_NUM - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (alloc) begin
            vld_q            <= vld_q & ~clash_vec;
            vld_q[alloc_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc) begin
            tag_q[alloc_idx]  <= look_addr;
            span_q[alloc_idx] <= alloc_span;
        end
    end

    assert_hit_unique_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/mc_store.sv
module mc_store #(
    parameter int DATA_W = 32,
    parameter int CA_W   = 5,
    localparam int WORDS = 1 << CA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CA_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CA_W-1:0]   rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        rd_data <= mem_q[rd_addr];
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assert_wr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + CA_W'(1));
endmodule

// File: rtl/method_cache.sv
module method_cache #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int BLK_NUM   = 8,
    parameter int BLK_WORDS = 4,
    parameter int LEN_W     = 8,
    localparam int IDX_W    = $clog2(BLK_NUM),
    localparam int OFF_W    = $clog2(BLK_WORDS),
    localparam int CA_W     = IDX_W + OFF_W,
    localparam int SIZE     = BLK_NUM * BLK_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    output logic              err,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic [CA_W-1:0]   fetch_addr,
    output logic [DATA_W-1:0] fetch_data
);
    import mc_pkg::*;

    mc_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  iss_q;
    logic [IDX_W-1:0]  base_q, ptr_q;
    logic [CA_W-1:0]   wr_cnt_q;
    logic              wr_pend_q;
    logic              err_q;

    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic              len_bad;
    logic [IDX_W:0]    span;
    logic              alloc;
    logic [CA_W-1:0]   base_word;

    assign len_bad   = (len_q == '0) || (len_q > LEN_W'(SIZE));
    assign span      = (IDX_W+1)'((len_q + LEN_W'(BLK_WORDS - 1)) >> OFF_W);
    assign alloc     = (state_q == ST_LOOKUP) && !len_bad && !hit;
    assign base_word = {base_q, {OFF_W{1'b0}}};

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = (len_bad || hit) ? ST_IDLE : ST_FILL;
            ST_FILL:   if (iss_q == len_q - LEN_W'(1)) state_d = ST_LAST;
            ST_LAST:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        mem_rd_en   = (state_q == ST_FILL);
        mem_rd_addr = addr_q + ADDR_W'(iss_q);
        err         = err_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            len_q     <= '0;
            iss_q     <= '0;
            base_q    <= '0;
            ptr_q     <= '0;
            wr_cnt_q  <= '0;
            wr_pend_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            wr_pend_q <= mem_rd_en;
            if (wr_pend_q) wr_cnt_q <= wr_cnt_q + CA_W'(1);
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        len_q  <= req_len;
                        err_q  <= 1'b0;
                    end
                end
                ST_LOOKUP: begin
                    if (len_bad) begin
                        err_q <= 1'b1;
                    end else if (hit) begin
                        base_q <= hit_idx;
                    end else begin
                        base_q   <= ptr_q;
                        ptr_q    <= ptr_q + span[IDX_W-1:0];
                        iss_q    <= '0;
                        wr_cnt_q <= '0;
                    end
                end
                ST_FILL: iss_q <= iss_q + LEN_W'(1);
                ST_LAST: ;
                default: ;
            endcase
        end
    end

    mc_tags #(.BLK_NUM(BLK_NUM), .ADDR_W(ADDR_W)) tags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_addr (addr_q),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .alloc     (alloc),
        .alloc_idx (ptr_q),
        .alloc_span(span)
    );

    mc_store #(.DATA_W(DATA_W), .CA_W(CA_W)) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_pend_q),
        .wr_addr(base_word + wr_cnt_q),
        .wr_data(mem_rd_data),
        .rd_addr(base_word + fetch_addr),
        .rd_data(fetch_data)
    );

    assert_busy_from_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
    assert_seq_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en && $past(mem_rd_en) |-> mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(1));
    assert_ptr_only_on_lookup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q != $past(ptr_q)) |-> ($past(state_q) == ST_LOOKUP));
    assert_err_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy && !mem_rd_en);
endmodule

// File: tb/method_cache_tb_top.sv
module method_cache_tb_top;
    localparam int N    = 8;
    localparam int BW   = 4;
    localparam int SIZE = N * BW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic        busy, err, mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic [4:0]  fetch_addr = '0;
    logic [31:0] fetch_data;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    method_cache dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .busy(busy), .err(err), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .fetch_addr(fetch_addr), .fetch_data(fetch_data)
    );

    function automatic logic [31:0] memf(input logic [15:0] a);
        return {a ^ 16'hC3A5, a};
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= memf(mem_rd_addr);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    int          phase = 0, dur = 0, kind = 0, mlen = 0, m_base = 0, m_ptr = 0;
    logic [15:0] maddr = '0;
    bit          m_err = 0;
    bit          own_v [N];
    int          own_s [N];
    logic [15:0] own_a [N];
    bit          cv [SIZE];
    logic [31:0] cw [SIZE];
    bit          exp_known = 0, coll = 0;
    logic [31:0] exp_fetch = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            phase = 0; m_base = 0; m_ptr = 0; m_err = 0; exp_known = 0; kind = 0;
            for (int b = 0; b < N; b++) own_v[b] = 0;
            for (int w = 0; w < SIZE; w++) cv[w] = 0;
        end else begin
            int ridx, widx;
            ridx = (m_base * BW + int'(fetch_addr)) % SIZE;
            exp_known = cv[ridx];
            exp_fetch = cw[ridx];
            coll = 0;
            if (kind == 1 && phase >= 3 && phase <= mlen + 2) begin
                widx = (m_base * BW + phase - 3) % SIZE;
                cw[widx] = memf(maddr + 16'(phase - 3));
                cv[widx] = 1;
                coll = (widx == ridx);
            end
            if (phase == 1) begin
                if (mlen == 0 || mlen > SIZE) begin
                    kind = 2; dur = 1; m_err = 1;
                end else begin
                    int found;
                    found = -1;
                    for (int b = 0; b < N; b++)
                        if (own_v[b] && own_s[b] == b && own_a[b] == maddr) found = b;
                    if (found >= 0) begin
                        kind = 0; dur = 1; m_base = found;
                    end else begin
                        int nb;
                        nb = (mlen + BW - 1) / BW;
                        kind = 1; dur = mlen + 2;
                        for (int j = 0; j < nb; j++) begin
                            int b, s;
                            b = (m_ptr + j) % N;
                            if (own_v[b]) begin
                                s = own_s[b];
                                for (int c = 0; c < N; c++)
                                    if (own_v[c] && own_s[c] == s) own_v[c] = 0;
                            end
                        end
                        for (int j = 0; j < nb; j++) begin
                            own_v[(m_ptr + j) % N] = 1;
                            own_s[(m_ptr + j) % N] = m_ptr;
                            own_a[(m_ptr + j) % N] = maddr;
                        end
                        m_base = m_ptr;
                        m_ptr = (m_ptr + nb) % N;
                    end
                end
            end
            if (phase != 0) begin
                if (phase == dur) phase = 0;
                else phase++;
            end else if (req_valid) begin
                phase = 1; maddr = req_addr; mlen = int'(req_len); m_err = 0;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit rd_e;
            rd_e = (kind == 1 && phase >= 2 && phase <= mlen + 1);
            chk(busy === (phase != 0), (kind == 0) ? "R3" : ((kind == 2) ? "R8" : "R4"),
                "busy", 32'(busy), 32'(phase != 0));
            chk(mem_rd_en === rd_e, "R4", "mem_rd_en", 32'(mem_rd_en), 32'(rd_e));
            if (rd_e)
                chk(mem_rd_addr === maddr + 16'(phase - 2), "R4", "mem_rd_addr",
                    32'(mem_rd_addr), 32'(maddr + 16'(phase - 2)));
            chk(err === m_err, "R8", "err", 32'(err), 32'(m_err));
            if (exp_known)
                chk(fetch_data === exp_fetch, coll ? "R9" : "R7", "fetch_data",
                    fetch_data, exp_fetch);
        end
    end

    task automatic do_req(input logic [15:0] a, input logic [7:0] l, input int exp_dur,
                          input string req, input bit noise, input bit collide);
        int cnt;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = l;
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 0;
        while (busy === 1'b1 && cnt < 300) begin
            cnt++;
            if (noise && cnt >= 3 && cnt <= 5) begin
                req_valid = 1'b1; req_addr = 16'h0777; req_len = 8'd3;
            end else begin
                req_valid = 1'b0;
            end
            if (collide) fetch_addr = 5'(cnt - 3);
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(cnt == exp_dur, req, "busy cycles", 32'(cnt), 32'(exp_dur));
    endtask

    task automatic sweep();
        for (int r = 0; r < 40; r++) begin
            @(negedge clk);
            fetch_addr = 5'(r);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0, "R1", "busy after reset", 32'(busy), 0);
        chk(err === 1'b0, "R1", "err after reset", 32'(err), 0);
        chk(mem_rd_en === 1'b0, "R1", "mem_rd_en after reset", 32'(mem_rd_en), 0);
        do_req(16'h0100, 8'd6, 8, "R1", 0, 0);          // A: blocks 0-1, miss
        sweep();
        do_req(16'h0100, 8'd6, 1, "R3", 0, 0);          // A hit
        do_req(16'h0200, 8'd16, 18, "R4", 0, 0);        // B: blocks 2-5
        sweep();
        do_req(16'h0300, 8'd12, 14, "R5", 0, 0);        // C: blocks 6,7,0 (wraps)
        sweep();                                          // R7 wrap through block 0
        do_req(16'h0100, 8'd6, 8, "R6", 0, 0);          // A dropped by C, reload at 1-2
        do_req(16'h0200, 8'd16, 18, "R6", 1, 1);        // B dropped by A; stray req, R9 overlap
        repeat (3) begin
            @(negedge clk);
            chk(busy === 1'b0, "R2", "no busy after ignored req", 32'(busy), 0);
        end
        sweep();
        do_req(16'h0100, 8'd6, 1, "R5", 0, 0);          // A kept: B placed at 3-6
        do_req(16'h0400, 8'd0, 1, "R8", 0, 0);
        chk(err === 1'b1, "R8", "err after len 0", 32'(err), 1);
        do_req(16'h0400, 8'd40, 1, "R8", 0, 0);
        chk(err === 1'b1, "R8", "err after oversize", 32'(err), 1);
        do_req(16'h0100, 8'd6, 1, "R8", 0, 0);          // tags untouched, err cleared
        chk(err === 1'b0, "R8", "err cleared", 32'(err), 0);
        sweep();
        do_req(16'h0500, 8'd32, 34, "R4", 0, 1);        // full-cache method
        sweep();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule